// File: doc/BRIEF.md
# Word-to-Byte Transmit/Receive Data Packer

This block connects a 32-bit register-style data port to two byte-wide queues, one for outgoing and one for incoming bytes. A write on the port is cut into four bytes that enter the transmit queue one per clock, lowest byte first. A read on the port drains up to four bytes from the receive queue, one per clock, and packs them into a word with the first byte in the lowest lane. The port response is held back until the byte sequence has finished, or has stopped early on a full or empty queue.

A serial engine outside this block pulls transmit bytes and delivers receive bytes through its own byte ports. The block maintains a 32-bit status word: full, empty and stall flags for each queue, a transmit depth count in words, a ready flag and an active flag. It also provides one-cycle overflow and underflow error pulses, separate flush inputs for each queue, and a soft reset. After reset or soft reset, the first transmit word is accepted and thrown away.

Top module: `word_byte_packer`

## Requirements
- R1: After reset the status word is 0x1100_0000 (transmit-empty at bit 28 and receive-empty at bit 24, all else zero), the port is ready and no transmit byte is available.
- R2: A transmit write accepted at clock edge N pushes bytes 0,1,2,3 of the word (bits 7:0 first) on edges N+1 to N+4, and the response pulse (data 0) follows edge N+4.
- R3: The first transmit write after reset or soft reset pushes nothing, changes no status bit and is answered with the response pulse after the accepting edge, with no error.
- R4: A transmit write that pushes all four bytes clears transmit-empty (bit 28), adds one to the word depth field (bits 7:0, saturating) and sets ready (bit 31).
- R5: When the transmit queue is full at a push step, the sequence stops, the bytes already pushed stay queued, transmit-full (bit 29) is set and the overflow pulse is given together with the response.
- R6: A receive read clears receive-full (bit 25) at the accepting edge, then pops up to four bytes, placing the byte popped k-th at bits 8k+7:8k, and a four-byte read answers after edge N+4 without error.
- R7: When the receive queue is empty at a pop step, the read returns the bytes gathered so far with zeros in the remaining lanes, sets receive-empty (bit 24) and gives the underflow pulse with the response.
- R8: A flush of a queue empties it, sets its empty flag, clears its full and stall flags and, for the transmit side, clears the word depth field; a flush wins over a push in the same cycle.
- R9: Popping the last transmit byte sets transmit-empty, clears the word depth field and clears transmit-full on any pop; pushing a receive byte clears receive-empty, and popping the last receive byte sets it.
- R10: An engine pop on an empty transmit queue sets transmit-stall (bit 27); an engine push on a full receive queue sets receive-stall (bit 23) and the byte is lost; receive-full (bit 25) is set when a push fills the queue.
- R11: While a byte sequence runs, active (bit 30) is high and the port does not accept a new request.
- R12: Soft reset empties both queues, returns the status word to its reset value, aborts any sequence and arms the first-word discard again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| flush_tx_i | input | 1 | Empty the transmit queue |
| flush_rx_i | input | 1 | Empty the receive queue |
| req_valid_i | input | 1 | Port request, taken when req_ready_o is high |
| req_write_i | input | 1 | 1: transmit word write, 0: receive word read |
| req_wdata_i | input | 32 | Word to transmit |
| req_ready_o | output | 1 | No sequence running |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_rdata_o | output | 32 | Read word, valid with the response |
| err_overflow_o | output | 1 | Transmit overflow pulse |
| err_underflow_o | output | 1 | Receive underflow pulse |
| status_o | output | 32 | Status word |
| tx_pop_i | input | 1 | Engine takes the head transmit byte |
| tx_byte_o | output | 8 | Head transmit byte |
| tx_avail_o | output | 1 | Transmit queue holds a byte |
| rx_push_i | input | 1 | Engine delivers a receive byte |
| rx_byte_i | input | 8 | Receive byte |
| rx_space_o | output | 1 | Receive queue has room |

## Verification
Each port response is due a fixed number of edges after the accepting edge: none for a discarded word, four for a full word, and one more than the bytes moved for a sequence cut short by a full or empty queue. The driver records the accepting cycle and queues the expected data, error bits and latency. The monitor counts edges until the pulse and compares every field against that entry. Status and engine-side byte checks are sampled on the falling edge after the edge that updates them, so each flag is read one register after its cause.

// File: rtl/word_pack_pkg.sv
package word_pack_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = LANES * BYTE_W;
   localparam int unsigned IDX_W  = $clog2(LANES);
   localparam int unsigned QD_W   = 8;

   localparam int unsigned ST_QD_LSB   = 0;
   localparam int unsigned ST_RX_STALL = 23;
   localparam int unsigned ST_RX_EMPTY = 24;
   localparam int unsigned ST_RX_FULL  = 25;
   localparam int unsigned ST_TX_STALL = 27;
   localparam int unsigned ST_TX_EMPTY = 28;
   localparam int unsigned ST_TX_FULL  = 29;
   localparam int unsigned ST_ACTIVE   = 30;
   localparam int unsigned ST_READY    = 31;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_TX   = 2'd1,
      SQ_RX   = 2'd2
   } seq_state_e;
endpackage

// File: rtl/packer_byte_fifo.sv
module packer_byte_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush_i,
   input  logic                         push_i,
   input  logic [DW-1:0]                din_i,
   input  logic                         pop_i,
   output logic [DW-1:0]                dout_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o,
   output logic                         empty_o,
   output logic                         full_o
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("packer_byte_fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          push_ok, pop_ok;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign dout_o  = mem_q[rd_q];
   assign count_o = cnt_q;

   always_ff @(posedge clk) begin
      if (push_ok && !flush_i) mem_q[wr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_q + AW'(1);
         if (pop_ok)  rd_q <= rd_q + AW'(1);
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R8: a flush leaves the queue empty on the next cycle
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (count_o == '0));
   // R5: the queue never holds more than its depth
   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (count_o <= CW'(DEPTH)));
endmodule

// File: rtl/packer_seq.sv
module packer_seq
   import word_pack_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst_i,
   input  logic                 req_valid_i,
   input  logic                 req_write_i,
   input  logic [WORD_W-1:0]    req_wdata_i,
   output logic                 req_ready_o,
   output logic                 resp_valid_o,
   output logic [WORD_W-1:0]    resp_rdata_o,
   output logic                 ovf_o,
   output logic                 unf_o,
   input  logic                 tx_full_i,
   output logic                 tx_push_o,
   output logic [BYTE_W-1:0]    tx_din_o,
   input  logic                 rx_empty_i,
   output logic                 rx_pop_o,
   input  logic [BYTE_W-1:0]    rx_dout_i,
   output logic                 tx_word_ok_o,
   output logic                 tx_ovf_now_o,
   output logic                 rx_unf_now_o,
   output logic                 rx_start_o,
   output logic                 active_o
);
   seq_state_e          st_q;
   logic [IDX_W-1:0]    idx_q;
   logic [WORD_W-1:0]   wbuf_q;
   logic                drop_pend_q;
   logic [LANES-1:0][BYTE_W-1:0] lanes;
   logic                last_step;

   assign req_ready_o  = (st_q == SQ_IDLE);
   assign active_o     = !req_ready_o;
   assign last_step    = (idx_q == IDX_W'(LANES - 1));
   assign tx_push_o    = (st_q == SQ_TX) && !tx_full_i && !soft_rst_i;
   assign tx_ovf_now_o = (st_q == SQ_TX) && tx_full_i && !soft_rst_i;
   assign rx_pop_o     = (st_q == SQ_RX) && !rx_empty_i && !soft_rst_i;
   assign rx_unf_now_o = (st_q == SQ_RX) && rx_empty_i && !soft_rst_i;
   assign tx_word_ok_o = tx_push_o && last_step;
   assign rx_start_o   = req_ready_o && req_valid_i && !req_write_i && !soft_rst_i;
   assign tx_din_o     = wbuf_q[BYTE_W*idx_q +: BYTE_W];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   lane_q <= '0;
            else if (rx_start_o)                          lane_q <= '0;
            else if (rx_pop_o && idx_q == IDX_W'(g))      lane_q <= rx_dout_i;
         end
         assign lanes[g] = lane_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= SQ_IDLE;
         idx_q        <= '0;
         wbuf_q       <= '0;
         drop_pend_q  <= 1'b1;
         resp_valid_o <= 1'b0;
         resp_rdata_o <= '0;
         ovf_o        <= 1'b0;
         unf_o        <= 1'b0;
      end else begin
         resp_valid_o <= 1'b0;
         ovf_o        <= 1'b0;
         unf_o        <= 1'b0;
         if (soft_rst_i) begin
            st_q        <= SQ_IDLE;
            idx_q       <= '0;
            drop_pend_q <= 1'b1;
         end else begin
            case (st_q)
               SQ_IDLE: if (req_valid_i) begin
                  idx_q <= '0;
                  if (!req_write_i) begin
                     st_q <= SQ_RX;
                  end else if (drop_pend_q) begin
                     drop_pend_q  <= 1'b0;
                     resp_valid_o <= 1'b1;
                     resp_rdata_o <= '0;
                  end else begin
                     wbuf_q <= req_wdata_i;
                     st_q   <= SQ_TX;
                  end
               end
               SQ_TX: begin
                  if (tx_full_i) begin
                     ovf_o        <= 1'b1;
                     resp_valid_o <= 1'b1;
                     resp_rdata_o <= '0;
                     st_q         <= SQ_IDLE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                     if (last_step) begin
                        resp_valid_o <= 1'b1;
                        resp_rdata_o <= '0;
                        st_q         <= SQ_IDLE;
                     end
                  end
               end
               SQ_RX: begin
                  if (rx_empty_i) begin
                     unf_o        <= 1'b1;
                     resp_valid_o <= 1'b1;
                     resp_rdata_o <= lanes;
                     st_q         <= SQ_IDLE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                     if (last_step) begin
                        resp_valid_o <= 1'b1;
                        resp_rdata_o <= {rx_dout_i, lanes[LANES-2:0]};
                        st_q         <= SQ_IDLE;
                     end
                  end
               end
               default: st_q <= SQ_IDLE;
            endcase
         end
      end
   end

   // R11: a request is never taken while a sequence is still pushing or popping
   a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push_o || rx_pop_o) |-> !req_ready_o);
endmodule

// File: rtl/word_byte_packer.sv
module word_byte_packer
   import word_pack_pkg::*;
#(
   parameter int unsigned DEPTH = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst_i,
   input  logic                 flush_tx_i,
   input  logic                 flush_rx_i,
   input  logic                 req_valid_i,
   input  logic                 req_write_i,
   input  logic [31:0]          req_wdata_i,
   output logic                 req_ready_o,
   output logic                 resp_valid_o,
   output logic [31:0]          resp_rdata_o,
   output logic                 err_overflow_o,
   output logic                 err_underflow_o,
   output logic [31:0]          status_o,
   input  logic                 tx_pop_i,
   output logic [7:0]           tx_byte_o,
   output logic                 tx_avail_o,
   input  logic                 rx_push_i,
   input  logic [7:0]           rx_byte_i,
   output logic                 rx_space_o
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_fempty, tx_ffull, rx_fempty, rx_ffull;
   logic              tx_push, rx_pop;
   logic [BYTE_W-1:0] tx_din, rx_dout;
   logic              tx_word_ok, tx_ovf_now, rx_unf_now, rx_start, active;
   logic              tx_pop_ok, rx_push_ok;

   logic [QD_W-1:0]   qd_q;
   logic              ready_q, tx_full_q, tx_empty_q, tx_stall_q;
   logic              rx_full_q, rx_empty_q, rx_stall_q;

   packer_byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) i_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_tx_i || soft_rst_i),
      .push_i(tx_push), .din_i(tx_din), .pop_i(tx_pop_i), .dout_o(tx_byte_o),
      .count_o(tx_cnt), .empty_o(tx_fempty), .full_o(tx_ffull));

   packer_byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) i_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_rx_i || soft_rst_i),
      .push_i(rx_push_i), .din_i(rx_byte_i), .pop_i(rx_pop), .dout_o(rx_dout),
      .count_o(rx_cnt), .empty_o(rx_fempty), .full_o(rx_ffull));

   packer_seq i_seq (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
      .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o), .resp_rdata_o(resp_rdata_o),
      .ovf_o(err_overflow_o), .unf_o(err_underflow_o),
      .tx_full_i(tx_ffull), .tx_push_o(tx_push), .tx_din_o(tx_din),
      .rx_empty_i(rx_fempty), .rx_pop_o(rx_pop), .rx_dout_i(rx_dout),
      .tx_word_ok_o(tx_word_ok), .tx_ovf_now_o(tx_ovf_now), .rx_unf_now_o(rx_unf_now),
      .rx_start_o(rx_start), .active_o(active));

   assign tx_avail_o = !tx_fempty;
   assign rx_space_o = !rx_ffull;
   assign tx_pop_ok  = tx_pop_i && !tx_fempty;
   assign rx_push_ok = rx_push_i && !rx_ffull;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qd_q <= '0; ready_q <= 1'b0;
         tx_full_q <= 1'b0; tx_empty_q <= 1'b1; tx_stall_q <= 1'b0;
      end else if (soft_rst_i) begin
         qd_q <= '0; ready_q <= 1'b0;
         tx_full_q <= 1'b0; tx_empty_q <= 1'b1; tx_stall_q <= 1'b0;
      end else if (flush_tx_i) begin
         qd_q <= '0;
         tx_full_q <= 1'b0; tx_empty_q <= 1'b1; tx_stall_q <= 1'b0;
         if (tx_word_ok) ready_q <= 1'b1;
      end else begin
         if (tx_word_ok) begin
            tx_empty_q <= 1'b0;
            ready_q    <= 1'b1;
            if (qd_q != '1) qd_q <= qd_q + QD_W'(1);
         end
         if (tx_pop_i && tx_fempty) tx_stall_q <= 1'b1;
         if (tx_pop_ok) begin
            tx_full_q <= 1'b0;
            if (tx_cnt == CW'(1) && !tx_push) begin
               tx_empty_q <= 1'b1;
               qd_q       <= '0;
            end
         end
         if (tx_ovf_now) tx_full_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full_q <= 1'b0; rx_empty_q <= 1'b1; rx_stall_q <= 1'b0;
      end else if (soft_rst_i || flush_rx_i) begin
         rx_full_q <= 1'b0; rx_empty_q <= 1'b1; rx_stall_q <= 1'b0;
      end else begin
         if (rx_push_i && rx_ffull) rx_stall_q <= 1'b1;
         if (rx_push_ok) begin
            rx_empty_q <= 1'b0;
            if (rx_cnt == CW'(DEPTH - 1) && !rx_pop) rx_full_q <= 1'b1;
         end
         if (rx_pop && rx_cnt == CW'(1) && !rx_push_ok) rx_empty_q <= 1'b1;
         if (rx_unf_now) rx_empty_q <= 1'b1;
         if (rx_start)   rx_full_q  <= 1'b0;
      end
   end

   always_comb begin
      status_o = '0;
      status_o[ST_QD_LSB +: QD_W] = qd_q;
      status_o[ST_RX_STALL] = rx_stall_q;
      status_o[ST_RX_EMPTY] = rx_empty_q;
      status_o[ST_RX_FULL]  = rx_full_q;
      status_o[ST_TX_STALL] = tx_stall_q;
      status_o[ST_TX_EMPTY] = tx_empty_q;
      status_o[ST_TX_FULL]  = tx_full_q;
      status_o[ST_ACTIVE]   = active;
      status_o[ST_READY]    = ready_q;
   end

   // R5: the overflow pulse only comes with a port response
   a_r5_ovf_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow_o |-> resp_valid_o);
   // R7: the underflow pulse only comes with a port response
   a_r7_unf_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow_o |-> resp_valid_o);
   // R4: a completed word leaves ready set
   a_r4_ready_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      tx_word_ok |=> status_o[ST_READY]);
   // R8: a transmit flush leaves the transmit side empty with zero depth
   a_r8_flush_tx_flags: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx_i |=> (status_o[ST_TX_EMPTY] && status_o[ST_QD_LSB +: QD_W] == '0));
   // R6: a receive read clears receive-full at its start
   a_r6_rx_full_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_start && !soft_rst_i) |=> !status_o[ST_RX_FULL]);
endmodule

// File: tb/test_word_byte_packer.sv
module test_word_byte_packer;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic soft_rst_i = 0, flush_tx_i = 0, flush_rx_i = 0;
   logic req_valid_i = 0, req_write_i = 0;
   logic [31:0] req_wdata_i = '0;
   logic req_ready_o, resp_valid_o, err_overflow_o, err_underflow_o;
   logic [31:0] resp_rdata_o, status_o;
   logic tx_pop_i = 0, rx_push_i = 0;
   logic [7:0] tx_byte_o, rx_byte_i = '0;
   logic tx_avail_o, rx_space_o;

   word_byte_packer #(.DEPTH(DEPTH)) i_word_byte_packer (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
      .flush_tx_i(flush_tx_i), .flush_rx_i(flush_rx_i),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
      .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o), .resp_rdata_o(resp_rdata_o),
      .err_overflow_o(err_overflow_o), .err_underflow_o(err_underflow_o),
      .status_o(status_o), .tx_pop_i(tx_pop_i), .tx_byte_o(tx_byte_o),
      .tx_avail_o(tx_avail_o), .rx_push_i(rx_push_i), .rx_byte_i(rx_byte_i),
      .rx_space_o(rx_space_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [31:0] d;
      bit          o;
      bit          u;
      int          lat;
      string       tag;
   } exp_t;
   exp_t q[$];
   exp_t mon_e;
   int n_cmp = 0, n_bad = 0, acc_cyc = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // monitor: pops the scoreboard on each response
   always @(negedge clk) begin
      if (rst_n && resp_valid_o) begin
         if (q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: unexpected response, actual %h expected none", resp_rdata_o);
         end else begin
            mon_e = q.pop_front();
            check({mon_e.tag, " data"}, resp_rdata_o, mon_e.d);
            check({mon_e.tag, " errors"}, {30'd0, err_overflow_o, err_underflow_o},
                  {30'd0, mon_e.o, mon_e.u});
            check({mon_e.tag, " latency"}, 32'(cyc - acc_cyc), 32'(mon_e.lat));
         end
      end
   end

   task automatic bus_op(bit wr, logic [31:0] wd, logic [31:0] ed, bit eo, bit eu,
                         int lat, string tag);
      exp_t e;
      e.d = ed; e.o = eo; e.u = eu; e.lat = lat; e.tag = tag;
      @(negedge clk);
      while (!req_ready_o) @(negedge clk);
      q.push_back(e);
      req_valid_i = 1; req_write_i = wr; req_wdata_i = wd;
      @(posedge clk); #1;
      req_valid_i = 0;
      acc_cyc = cyc;
      if (lat > 0) begin
         @(negedge clk);
         check("R11 active and busy", {30'd0, status_o[30], req_ready_o}, 32'd2);
      end
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic eng_pop(logic [7:0] exp, string tag);
      @(negedge clk);
      check(tag, {23'd0, tx_avail_o, tx_byte_o}, {23'd0, 1'b1, exp});
      tx_pop_i = 1;
      @(posedge clk); #1;
      tx_pop_i = 0;
   endtask

   task automatic eng_pop_empty();
      @(negedge clk);
      tx_pop_i = 1;
      @(posedge clk); #1;
      tx_pop_i = 0;
   endtask

   task automatic eng_push(logic [7:0] b);
      @(negedge clk);
      rx_push_i = 1; rx_byte_i = b;
      @(posedge clk); #1;
      rx_push_i = 0;
   endtask

   task automatic stat(logic [31:0] exp, string tag);
      @(negedge clk);
      check(tag, status_o, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      stat(32'h1100_0000, "R1 status");
      check("R1 ready/avail", {30'd0, req_ready_o, tx_avail_o}, 32'd2);

      // R3 first word discarded
      bus_op(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R3");
      stat(32'h1100_0000, "R3 status");
      check("R3 nothing queued", {31'd0, tx_avail_o}, 0);

      // R2 and R4 full word, LSB first
      bus_op(1, 32'h4433_2211, 0, 0, 0, 4, "R2");
      stat(32'h8100_0001, "R4 status");
      eng_pop(8'h11, "R2 b0"); eng_pop(8'h22, "R2 b1");
      eng_pop(8'h33, "R2 b2"); eng_pop(8'h44, "R2 b3");
      stat(32'h9100_0000, "R9 tx drained");

      // R5 overflow at the first push step
      bus_op(1, 32'h0D0C_0B0A, 0, 0, 0, 4, "R2 w1");
      bus_op(1, 32'h1D1C_1B1A, 0, 0, 0, 4, "R2 w2");
      stat(32'h8100_0002, "R4 depth two");
      bus_op(1, 32'h2D2C_2B2A, 0, 1, 0, 1, "R5 full");
      stat(32'hA100_0002, "R5 status");
      for (int i = 0; i < 4; i++) eng_pop(8'h0A + 8'(i), "R5 keep w1");
      for (int i = 0; i < 4; i++) eng_pop(8'h1A + 8'(i), "R5 keep w2");
      stat(32'h9100_0000, "R9 drain clears full");

      // R5 overflow part way through a word
      bus_op(1, 32'h0302_0100, 0, 0, 0, 4, "R2 a");
      eng_pop(8'h00, "R2 a0");
      bus_op(1, 32'h1312_1110, 0, 0, 0, 4, "R2 b");
      bus_op(1, 32'h2322_2120, 0, 1, 0, 2, "R5 partial");
      eng_pop(8'h01, "R5 p"); eng_pop(8'h02, "R5 p"); eng_pop(8'h03, "R5 p");
      eng_pop(8'h10, "R5 p"); eng_pop(8'h11, "R5 p"); eng_pop(8'h12, "R5 p");
      eng_pop(8'h13, "R5 p"); eng_pop(8'h20, "R5 p");
      stat(32'h9100_0000, "R9 drained");

      // R10 transmit stall, R8 transmit flush
      eng_pop_empty();
      stat(32'h9900_0000, "R10 tx stall");
      @(negedge clk); flush_tx_i = 1; @(posedge clk); #1; flush_tx_i = 0;
      stat(32'h9100_0000, "R8 tx flush");

      // R6 four byte read
      eng_push(8'hAA); eng_push(8'hBB); eng_push(8'hCC); eng_push(8'hDD);
      stat(32'h9000_0000, "R9 rx not empty");
      bus_op(0, 0, 32'hDDCC_BBAA, 0, 0, 4, "R6 read");
      stat(32'h9100_0000, "R9 rx drained");

      // R7 partial and empty reads
      eng_push(8'h5A); eng_push(8'hA5);
      bus_op(0, 0, 32'h0000_A55A, 0, 1, 3, "R7 partial");
      stat(32'h9100_0000, "R7 status");
      bus_op(0, 0, 32'h0, 0, 1, 1, "R7 empty");

      // R10 receive full and stall, R6 full cleared on read
      for (int i = 0; i < 8; i++) eng_push(8'h80 + 8'(i));
      stat(32'h9200_0000, "R10 rx full");
      eng_push(8'hFF);
      stat(32'h9280_0000, "R10 rx stall");
      bus_op(0, 0, 32'h8382_8180, 0, 0, 4, "R6 read full");
      stat(32'h9080_0000, "R6 full cleared");
      bus_op(0, 0, 32'h8786_8584, 0, 0, 4, "R10 second half");
      stat(32'h9180_0000, "R10 stall kept");
      bus_op(0, 0, 32'h0, 0, 1, 1, "R10 byte lost");

      // R8 flush both sides
      bus_op(1, 32'h5566_7788, 0, 0, 0, 4, "R2 pre flush");
      eng_push(8'h11);
      stat(32'h8080_0001, "R8 pre flush");
      @(negedge clk); flush_tx_i = 1; flush_rx_i = 1;
      @(posedge clk); #1; flush_tx_i = 0; flush_rx_i = 0;
      stat(32'h9100_0000, "R8 both flushed");
      check("R8 tx gone", {31'd0, tx_avail_o}, 0);
      bus_op(0, 0, 32'h0, 0, 1, 1, "R8 rx gone");

      // R12 soft reset
      bus_op(1, 32'h9999_9999, 0, 0, 0, 4, "R2 pre soft");
      @(negedge clk); soft_rst_i = 1; @(posedge clk); #1; soft_rst_i = 0;
      stat(32'h1100_0000, "R12 status");
      check("R12 tx cleared", {31'd0, tx_avail_o}, 0);
      bus_op(1, 32'hCAFE_F00D, 0, 0, 0, 0, "R12 drop again");
      check("R12 dropped", {31'd0, tx_avail_o}, 0);
      bus_op(1, 32'h0403_0201, 0, 0, 0, 4, "R12 next word");
      eng_pop(8'h01, "R12 first byte");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule